// File: doc/BRIEF.md
# Write-Buffer Width Calculator

Each cache bank uses this block to decide how many of its least-recently-used ways it may hold back as an in-cache write buffer. Two per-position histograms are kept, indexed by recency-stack position: one counts read hits and the other counts write hits. For each histogram the block looks for the widest tail of LRU ways whose share of that histogram's hits stays within a programmable fraction. The smaller of the two widths is taken, with a floor applied so the buffer is never narrower than a fixed minimum.

The work is done once per epoch. After an epoch-end strobe, a sequential walk visits one recency position per cycle, starting at the LRU end. Cross-multiplication replaces division. When the walk finishes, the block latches the two limits and the final width, raises a one-cycle done pulse, and halves every counter so that older history weighs less in the next epoch.

Top module: `wbuf_width_calc`

## Requirements
- R1: After reset, `rd_lim`, `wr_lim` and `wb_width` are all WAYS (16). `busy` and `done` are low.
- R2: Position 0 is the LRU end and position WAYS-1 is the MRU end. A `rd_hit` adds one to the read counter at `rd_pos`. A `wr_hit` adds one to the write counter at `wr_pos`. Both are counted when they arrive in the same cycle. A counter holds at 2^CNT_W-1 and never wraps.
- R3: The read limit is the largest w in 0..WAYS for which (read hits at positions 0..w-1) * 2^FRAC_W <= `rd_thr` * (total read hits). `rd_thr` is an unsigned fraction of 2^FRAC_W.
- R4: The write limit follows the R3 rule, using the write histogram and `wr_thr`.
- R5: When a histogram holds no hits at epoch end, its limit is WAYS.
- R6: `wb_width` = max(FLOOR, min(`rd_lim`, `wr_lim`)), with FLOOR = 3.
- R7: `epoch_end` is taken only while `busy` is low. `busy` then stays high for 16 cycles. `done` pulses high for exactly one cycle, in the 16th cycle after the one in which the strobe was sampled. The three outputs update on the same edge that raises `done`.
- R8: While `busy` is high, hit events and further `epoch_end` strobes have no effect.
- R9: On the edge that raises `done`, every counter becomes floor(count/2). The next epoch's limits are computed from these halved values plus any new hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_hit | input | 1 | Read hit event |
| rd_pos | input | 4 | Recency position of the read hit |
| wr_hit | input | 1 | Write hit event |
| wr_pos | input | 4 | Recency position of the write hit |
| epoch_end | input | 1 | Epoch-end strobe; starts the walk |
| rd_thr | input | 8 | Read share bound, fraction of 256 |
| wr_thr | input | 8 | Write share bound, fraction of 256 |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when new results latch |
| rd_lim | output | 5 | Read-limited width |
| wr_lim | output | 5 | Write-limited width |
| wb_width | output | 5 | Final write-buffer width |

## Verification
Counter saturation is the hardest case to reach from the ports. The bench reaches it by instantiating the block with narrow 8-bit counters and driving 300 read hits into the LRU position. It then sets the read bound so that the saturated count and the true count give different widths. Halving is covered by a chain of epochs with no new hits, which drains the histograms until both limits return to full associativity. Hits and extra strobes are injected during a walk, and their absence is then checked through the next epoch's result.

// File: rtl/wbuf_width_calc.sv
module wbuf_width_calc #(
  parameter int WAYS   = 16,
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8,
  parameter int FLOOR  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_hit,
  input  logic [$clog2(WAYS)-1:0]      rd_pos,
  input  logic                         wr_hit,
  input  logic [$clog2(WAYS)-1:0]      wr_pos,
  input  logic                         epoch_end,
  input  logic [FRAC_W-1:0]            rd_thr,
  input  logic [FRAC_W-1:0]            wr_thr,
  output logic                         busy,
  output logic                         done,
  output logic [$clog2(WAYS+1)-1:0]    rd_lim,
  output logic [$clog2(WAYS+1)-1:0]    wr_lim,
  output logic [$clog2(WAYS+1)-1:0]    wb_width
);
  localparam int PW = $clog2(WAYS);
  localparam int LW = $clog2(WAYS + 1);
  localparam int TW = CNT_W + PW + 1;
  localparam int MW = TW + FRAC_W;

  logic [WAYS-1:0][CNT_W-1:0] rd_cnt, wr_cnt;
  logic [TW-1:0] rd_tot, wr_tot, rd_sum, wr_sum;
  logic [PW-1:0] idx;
  logic          rd_ok, wr_ok;
  logic [LW-1:0] rd_n, wr_n;

  always_comb begin
    rd_tot = '0;
    wr_tot = '0;
    for (int i = 0; i < WAYS; i++) begin
      rd_tot = rd_tot + TW'(rd_cnt[i]);
      wr_tot = wr_tot + TW'(wr_cnt[i]);
    end
  end

  wire [TW-1:0] rd_sum_nx = rd_sum + TW'(rd_cnt[idx]);
  wire [TW-1:0] wr_sum_nx = wr_sum + TW'(wr_cnt[idx]);
  wire rd_fit = (MW'(rd_sum_nx) << FRAC_W) <= MW'(rd_thr) * MW'(rd_tot);
  wire wr_fit = (MW'(wr_sum_nx) << FRAC_W) <= MW'(wr_thr) * MW'(wr_tot);
  wire rd_ok_nx = rd_ok & rd_fit;
  wire wr_ok_nx = wr_ok & wr_fit;
  wire [LW-1:0] rd_n_nx = rd_n + LW'(rd_ok_nx);
  wire [LW-1:0] wr_n_nx = wr_n + LW'(wr_ok_nx);
  wire last = busy && (idx == PW'(WAYS - 1));

  wire [LW-1:0] rd_res = (rd_tot == '0) ? LW'(WAYS) : rd_n_nx;
  wire [LW-1:0] wr_res = (wr_tot == '0) ? LW'(WAYS) : wr_n_nx;
  wire [LW-1:0] mn_res = (rd_res < wr_res) ? rd_res : wr_res;
  wire [LW-1:0] wd_res = (mn_res < LW'(FLOOR)) ? LW'(FLOOR) : mn_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; idx <= '0;
      rd_sum <= '0; wr_sum <= '0; rd_ok <= 1'b0; wr_ok <= 1'b0;
      rd_n <= '0; wr_n <= '0;
      rd_lim <= LW'(WAYS); wr_lim <= LW'(WAYS); wb_width <= LW'(WAYS);
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (epoch_end) begin
          busy <= 1'b1; idx <= '0;
          rd_sum <= '0; wr_sum <= '0; rd_ok <= 1'b1; wr_ok <= 1'b1;
          rd_n <= '0; wr_n <= '0;
        end
      end else if (last) begin
        busy <= 1'b0; done <= 1'b1;
        rd_lim <= rd_res; wr_lim <= wr_res; wb_width <= wd_res;
      end else begin
        idx <= idx + 1'b1;
        rd_sum <= rd_sum_nx; wr_sum <= wr_sum_nx;
        rd_ok <= rd_ok_nx; wr_ok <= wr_ok_nx;
        rd_n <= rd_n_nx; wr_n <= wr_n_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt <= '0;
      wr_cnt <= '0;
    end else begin
      for (int i = 0; i < WAYS; i++) begin
        if (!busy) begin
          if (rd_hit && rd_pos == PW'(i) && rd_cnt[i] != '1) rd_cnt[i] <= rd_cnt[i] + 1'b1;
          if (wr_hit && wr_pos == PW'(i) && wr_cnt[i] != '1) wr_cnt[i] <= wr_cnt[i] + 1'b1;
        end else if (last) begin
          rd_cnt[i] <= rd_cnt[i] >> 1;
          wr_cnt[i] <= wr_cnt[i] >> 1;
        end
      end
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_ends_walk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  a_r6_width_range: assert property (@(posedge clk) disable iff (!rst_n)
    wb_width >= LW'(FLOOR) && wb_width <= LW'(WAYS));
  a_r6_width_source: assert property (@(posedge clk) disable iff (!rst_n)
    wb_width == rd_lim || wb_width == wr_lim || wb_width == LW'(FLOOR));
  a_r8_frozen_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> $stable(rd_cnt) && $stable(wr_cnt));
  a_r3_hold_between_epochs: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rd_lim) && $stable(wr_lim) && $stable(wb_width));
  a_r9_halve_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> rd_cnt[0] == ($past(rd_cnt[0]) >> 1));
endmodule

// File: tb/wbuf_width_calc_test.sv
`timescale 1ns/1ps
module wbuf_width_calc_test;
  localparam int WAYS = 16, CNTW = 8, FW = 8, SAT = (1 << CNTW) - 1;

  logic clk = 0, rst_n = 0;
  logic rd_hit = 0, wr_hit = 0, epoch_end = 0;
  logic [3:0] rd_pos = 0, wr_pos = 0;
  logic [7:0] rd_thr = 0, wr_thr = 0;
  logic busy, done;
  logic [4:0] rd_lim, wr_lim, wb_width;

  always #2.5 clk = ~clk;

  wbuf_width_calc #(.WAYS(WAYS), .CNT_W(CNTW), .FRAC_W(FW), .FLOOR(3)) uut (
    .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .rd_pos(rd_pos), .wr_hit(wr_hit),
    .wr_pos(wr_pos), .epoch_end(epoch_end), .rd_thr(rd_thr), .wr_thr(wr_thr),
    .busy(busy), .done(done), .rd_lim(rd_lim), .wr_lim(wr_lim), .wb_width(wb_width));

  int mr[WAYS], mw[WAYS];
  int nchk = 0, nbad = 0;
  int qr[$], qw[$], qx[$];

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mlim(bit rd, int thr);
    int tot = 0, s = 0, n = 0;
    for (int i = 0; i < WAYS; i++) tot += rd ? mr[i] : mw[i];
    if (tot == 0) return WAYS;
    for (int w = 1; w <= WAYS; w++) begin
      s += rd ? mr[w-1] : mw[w-1];
      if (s * (1 << FW) <= thr * tot) n = w; else break;
    end
    return n;
  endfunction

  // R2: drive n cycles of hits, model saturates at SAT
  task automatic hits(bit r, bit w, int pr, int pw, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rd_hit = r; wr_hit = w; rd_pos = 4'(pr); wr_pos = 4'(pw);
      if (r && mr[pr] < SAT) mr[pr]++;
      if (w && mw[pw] < SAT) mw[pw]++;
    end
    @(negedge clk);
    rd_hit = 0; wr_hit = 0;
  endtask

  // R7/R8: run one epoch; optionally inject ignored traffic during the walk
  task automatic epoch(int tr, int tw, bit inject);
    int a, b, m;
    rd_thr = 8'(tr); wr_thr = 8'(tw);
    a = mlim(1, tr); b = mlim(0, tw);
    m = (a < b) ? a : b;
    qr.push_back(a); qw.push_back(b); qx.push_back(m < 3 ? 3 : m);
    for (int i = 0; i < WAYS; i++) begin mr[i] /= 2; mw[i] /= 2; end
    @(negedge clk); epoch_end = 1;
    @(negedge clk); epoch_end = inject;
    if (inject) begin rd_hit = 1; wr_hit = 1; rd_pos = 4'd0; wr_pos = 4'd0; end
    for (int k = 0; k < 14; k++) @(negedge clk);
    rd_hit = 0; wr_hit = 0; epoch_end = 0;
    @(negedge clk);
    chk("R7 busy before done", busy, 1);
    chk("R7 no early done", done, 0);
    @(negedge clk);
    chk("R7 done in 16th cycle", done, 1);
    @(negedge clk);
    chk("R7 done single cycle", done, 0);
    chk("R7 idle after walk", busy, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (qr.size() == 0) chk("R7 unexpected done", 1, 0);
      else begin
        chk("R3 read limit", rd_lim, qr.pop_front());
        chk("R4 write limit", wr_lim, qw.pop_front());
        chk("R6 final width", wb_width, qx.pop_front());
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    chk("watchdog expired", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < WAYS; i++) begin mr[i] = 0; mw[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset rd_lim", rd_lim, 16);
    chk("R1 reset wr_lim", wr_lim, 16);
    chk("R1 reset width", wb_width, 16);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);

    epoch(64, 64, 0);                       // R5 empty histograms
    hits(1, 0, 15, 0, 10); hits(1, 0, 3, 0, 2); hits(0, 1, 0, 0, 5);
    hits(0, 1, 9, 9, 20);
    epoch(64, 128, 0);                      // R3 R4 spread pattern
    hits(1, 0, 0, 0, 20);
    epoch(32, 200, 0);                      // R6 floor clamp
    hits(1, 1, 2, 5, 8);
    epoch(128, 100, 0);                     // R2 simultaneous read and write
    hits(1, 0, 7, 0, 6); hits(0, 1, 1, 1, 3); hits(0, 1, 14, 14, 30);
    epoch(180, 20, 0);                      // R4 write limit smaller
    epoch(90, 90, 1);                       // R8 traffic injected while busy
    epoch(90, 90, 0);                       // R8 R9 result reflects halving only
    hits(1, 0, 0, 0, 300); hits(1, 0, 15, 15, 100);
    epoch(185, 64, 0);                      // R2 saturated counter
    for (int k = 0; k < 9; k++) epoch(100, 100, 0); // R9 drain to empty, R5
    chk("R9 drained read limit", rd_lim, 16);
    chk("R7 all results seen", qr.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule